// File: doc/BRIEF.md
# Cascaded Dual-Output Clock Divider

This block derives two output clocks from one fast oscillator clock. A first-stage prescaler divides the oscillator by a small integer between 5 and 11. Its output feeds two second-stage dividers in parallel, each with its own ratio from 1 to 1023. Output k therefore toggles at the oscillator frequency divided by M_k = P x D_k. Both output pins are registered in the oscillator domain, and the prescaler is a clock enable rather than a derived clock, so the block has a single clock domain. Each output has a true pin and a complementary pin. A per-output mode bit makes the complementary pin either the inverse of the true pin (differential) or an in-phase copy of it (single-ended).

The ratios and mode bits are sampled once, on the first clock after reset is released. A hold input parks the outputs at a static level, for example while the oscillator is being calibrated. When hold is released, every counter restarts from zero on the same cycle. An illegal configuration is reported on `cfg_err_o`, and all pins stay low until the next reset.

A four-state controller sequences the block. ST_LOAD is the reset state and captures the configuration. From ST_LOAD the controller takes one of three transitions: to ST_FAULT if the configuration is illegal, to ST_HOLD if hold is asserted, and to ST_RUN otherwise. ST_RUN moves to ST_HOLD when hold is asserted, and ST_HOLD moves back to ST_RUN when hold is released. ST_FAULT is left only through reset.

Top module: `casc_clkdiv`

## Requirements
- R1: `pre_ratio_i` (unsigned, 5 to 11) sets the prescaler ratio P. With a second-stage ratio of 1, an output has period P and is high for ceil(P/2) cycles, which is the prescaler waveform passed straight through.
- R2: Output k has a period of exactly P x D_k oscillator cycles. D_1 is `div1_ratio_i` and D_2 is `div2_ratio_i`, each a 10-bit unsigned value from 1 to 1023. The two outputs are independent of each other.
- R3: An output with total ratio M is high for ceil(M/2) cycles and low for floor(M/2) cycles. Even M gives an exact 50% duty cycle; odd M gives a high time one cycle longer than the low time.
- R4: Ratios and mode bits are captured on the first rising clock edge after `rst_ni` goes high. Later changes on those inputs have no effect until the next reset.
- R5: From the second clock edge after `hold_i` is sampled high, both true pins stay low and both complementary pins hold a static level (high in differential mode, low in single-ended mode) for as long as hold stays asserted.
- R6: When `hold_i` is sampled low in ST_HOLD, all counters restart from zero and both true pins rise on the second edge after that sample. When one ratio is a multiple of the other, every rising edge of the slower output coincides with a rising edge of the faster one.
- R7: `single_end_i[k-1]` = 0 makes `outk_n_o` the inverse of `outk_p_o`; a value of 1 makes it an identical copy.
- R8: P below 5, P above 11, D_1 = 0 or D_2 = 0 drives `cfg_err_o` high from the first edge after reset release. All four output pins then stay low until the next reset.
- R9: While `rst_ni` is low, all four output pins and `cfg_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hold_i | input | 1 | Park outputs at a static level, restart on release |
| pre_ratio_i | input | 4 | Prescaler ratio P, sampled after reset |
| div1_ratio_i | input | 10 | Second-stage ratio for output 1 |
| div2_ratio_i | input | 10 | Second-stage ratio for output 2 |
| single_end_i | input | 2 | Per-output mode: bit 0 output 1, bit 1 output 2; 1 = single-ended |
| out1_p_o | output | 1 | Output 1 true pin |
| out1_n_o | output | 1 | Output 1 complementary pin |
| out2_p_o | output | 1 | Output 2 true pin |
| out2_n_o | output | 1 | Output 2 complementary pin |
| cfg_err_o | output | 1 | Illegal configuration captured |

## Verification
The assertions check these properties on every cycle:
- the counters stay within their captured ratios;
- the captured configuration is frozen outside ST_LOAD;
- the counters are zero on the first cycle after leaving hold;
- the pins are static during hold and dark in fault;
- the complementary pin follows its mode.

Properties that need whole periods can only be shown by the bench scenarios. These are the exact period and high/low split for even and odd totals up to the largest ratios, the independence of the two outputs, the edge alignment after hold release, and the fact that ratio changes after reset are ignored.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    localparam int PRE_W   = 4;
    localparam int DIV_W   = 10;
    localparam int PRE_MIN = 5;
    localparam int PRE_MAX = 11;
    localparam int NUM_OUT = 2;
    localparam int POS_W   = PRE_W + DIV_W;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_FAULT = 2'd1,
        ST_HOLD  = 2'd2,
        ST_RUN   = 2'd3
    } cdiv_state_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [POS_W-1:0] half;
        logic             se;
    } out_cfg_t;

endpackage

// File: rtl/cdiv_ctrl_fsm.sv
module cdiv_ctrl_fsm
    import cdiv_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        hold_i,
    input  logic        cfg_bad_i,
    output cdiv_state_e state_o,
    output logic        load_o,
    output logic        run_o,
    output logic        dark_o,
    output logic        fault_o
);

    cdiv_state_e state_q;
    cdiv_state_e state_d;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_LOAD;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD: begin
                if (cfg_bad_i) begin
                    state_d = ST_FAULT;
                end else if (hold_i) begin
                    state_d = ST_HOLD;
                end else begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (hold_i) begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (!hold_i) begin
                    state_d = ST_RUN;
                end
            end
            ST_FAULT: begin
                state_d = ST_FAULT;
            end
            default: begin
                state_d = ST_LOAD;
            end
        endcase
    end

    // outputs
    always_comb begin
        load_o  = 1'b0;
        run_o   = 1'b0;
        dark_o  = 1'b0;
        fault_o = 1'b0;
        unique case (state_q)
            ST_LOAD: begin
                load_o = 1'b1;
                dark_o = 1'b1;
            end
            ST_FAULT: begin
                fault_o = 1'b1;
                dark_o  = 1'b1;
            end
            ST_RUN: begin
                run_o = 1'b1;
            end
            ST_HOLD: begin
                run_o = 1'b0;
            end
            default: begin
                dark_o = 1'b1;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/cdiv_prescaler.sv
module cdiv_prescaler
    import cdiv_pkg::*;
#(
    parameter int W = PRE_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         run_i,
    input  logic [W-1:0] ratio_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;

    assign wrap_o = run_i && (cnt_q == ratio_i - ONE);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (!run_i || wrap_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/cdiv_stage.sv
module cdiv_stage
    import cdiv_pkg::*;
#(
    parameter int PW = PRE_W,
    parameter int DW = DIV_W,
    parameter int QW = POS_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          run_i,
    input  logic          dark_i,
    input  logic          wrap_i,
    input  logic [PW-1:0] pcnt_i,
    input  logic [PW-1:0] pre_i,
    input  logic [DW-1:0] div_i,
    input  logic [QW-1:0] half_i,
    input  logic          se_i,
    output logic [DW-1:0] dcnt_o,
    output logic          p_o,
    output logic          n_o
);

    localparam logic [DW-1:0] ONE = DW'(1);

    logic [DW-1:0] dcnt_q;
    logic [QW-1:0] pos;
    logic          p_nx;
    logic          n_nx;
    logic          p_q;
    logic          n_q;

    // second-stage counter advances once per prescaler period
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dcnt_q <= '0;
        end else if (!run_i) begin
            dcnt_q <= '0;
        end else if (wrap_i) begin
            if (dcnt_q == div_i - ONE) begin
                dcnt_q <= '0;
            end else begin
                dcnt_q <= dcnt_q + ONE;
            end
        end
    end

    // oscillator-cycle position inside the output period
    assign pos  = QW'(dcnt_q) * QW'(pre_i) + QW'(pcnt_i);
    assign p_nx = run_i && (pos < half_i);

    always_comb begin
        if (dark_i) begin
            n_nx = 1'b0;
        end else if (se_i) begin
            n_nx = p_nx;
        end else begin
            n_nx = ~p_nx;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            p_q <= 1'b0;
            n_q <= 1'b0;
        end else begin
            p_q <= p_nx;
            n_q <= n_nx;
        end
    end

    assign dcnt_o = dcnt_q;
    assign p_o    = p_q;
    assign n_o    = n_q;

endmodule

// File: rtl/casc_clkdiv.sv
module casc_clkdiv
    import cdiv_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hold_i,
    input  logic [PRE_W-1:0] pre_ratio_i,
    input  logic [DIV_W-1:0] div1_ratio_i,
    input  logic [DIV_W-1:0] div2_ratio_i,
    input  logic [NUM_OUT-1:0] single_end_i,
    output logic             out1_p_o,
    output logic             out1_n_o,
    output logic             out2_p_o,
    output logic             out2_n_o,
    output logic             cfg_err_o
);

    cdiv_state_e      state_q;
    logic             load;
    logic             run;
    logic             dark;
    logic             fault;
    logic             cfg_bad;
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pcnt;
    logic             wrap;

    logic [DIV_W-1:0] div_in [NUM_OUT];
    logic [NUM_OUT-1:0] div_zero;
    out_cfg_t         ocfg_q [NUM_OUT];
    logic [DIV_W-1:0] dcnt_w [NUM_OUT];
    logic [NUM_OUT-1:0] pin_p;
    logic [NUM_OUT-1:0] pin_n;

    assign div_in[0] = div1_ratio_i;
    assign div_in[1] = div2_ratio_i;

    // legality of the raw configuration, judged while it is captured
    always_comb begin
        cfg_bad = (pre_ratio_i < PRE_W'(PRE_MIN)) || (pre_ratio_i > PRE_W'(PRE_MAX));
        cfg_bad = cfg_bad || (|div_zero);
    end

    cdiv_ctrl_fsm u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .hold_i    (hold_i),
        .cfg_bad_i (cfg_bad),
        .state_o   (state_q),
        .load_o    (load),
        .run_o     (run),
        .dark_o    (dark),
        .fault_o   (fault)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pre_q <= '0;
        end else if (load) begin
            pre_q <= pre_ratio_i;
        end
    end

    cdiv_prescaler #(.W(PRE_W)) u_pre (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (run),
        .ratio_i (pre_q),
        .cnt_o   (pcnt),
        .wrap_o  (wrap)
    );

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        logic [POS_W-1:0] prod;
        logic [POS_W-1:0] half_nx;

        assign div_zero[k] = (div_in[k] == '0);
        assign prod        = POS_W'(pre_ratio_i) * POS_W'(div_in[k]);
        assign half_nx     = (prod + POS_W'(1)) >> 1;

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                ocfg_q[k] <= '0;
            end else if (load) begin
                ocfg_q[k].div  <= div_in[k];
                ocfg_q[k].half <= half_nx;
                ocfg_q[k].se   <= single_end_i[k];
            end
        end

        cdiv_stage #(.PW(PRE_W), .DW(DIV_W), .QW(POS_W)) u_stage (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .run_i  (run),
            .dark_i (dark),
            .wrap_i (wrap),
            .pcnt_i (pcnt),
            .pre_i  (pre_q),
            .div_i  (ocfg_q[k].div),
            .half_i (ocfg_q[k].half),
            .se_i   (ocfg_q[k].se),
            .dcnt_o (dcnt_w[k]),
            .p_o    (pin_p[k]),
            .n_o    (pin_n[k])
        );
    end

    assign out1_p_o  = pin_p[0];
    assign out1_n_o  = pin_n[0];
    assign out2_p_o  = pin_p[1];
    assign out2_n_o  = pin_n[1];
    assign cfg_err_o = fault;

endmodule

// File: rtl/casc_clkdiv_chk.sv
module casc_clkdiv_chk
    import cdiv_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input cdiv_state_e      state_i,
    input logic [PRE_W-1:0] pcnt_i,
    input logic [PRE_W-1:0] pre_i,
    input logic [DIV_W-1:0] dcnt0_i,
    input logic [DIV_W-1:0] dcnt1_i,
    input logic [DIV_W-1:0] div0_i,
    input logic [DIV_W-1:0] div1_i,
    input logic             se0_i,
    input logic             se1_i,
    input logic             out1_p_i,
    input logic             out1_n_i,
    input logic             out2_p_i,
    input logic             out2_n_i,
    input logic             cfg_err_i
);

    assert_pcnt_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == ST_RUN) |-> (pcnt_i < pre_i));

    assert_dcnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == ST_RUN) |-> ((dcnt0_i < div0_i) && (dcnt1_i < div1_i)));

    assert_cfg_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(state_i) != ST_LOAD) |->
            ($stable(pre_i) && $stable(div0_i) && $stable(div1_i) && $stable(se0_i) && $stable(se1_i)));

    assert_hold_static_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((state_i == ST_HOLD) && ($past(state_i) == ST_HOLD) && ($past(state_i, 2) == ST_HOLD)) |->
            (!out1_p_i && !out2_p_i && $stable(out1_n_i) && $stable(out2_n_i)));

    assert_restart_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((state_i == ST_RUN) && ($past(state_i) == ST_HOLD)) |->
            ((pcnt_i == '0) && (dcnt0_i == '0) && (dcnt1_i == '0)));

    assert_comp_mode_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (($past(state_i) == ST_RUN) || ($past(state_i) == ST_HOLD)) |->
            ((out1_n_i == (se0_i ? out1_p_i : !out1_p_i)) &&
             (out2_n_i == (se1_i ? out2_p_i : !out2_p_i))));

    assert_fault_dark_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_err_i |-> (!out1_p_i && !out1_n_i && !out2_p_i && !out2_n_i));

endmodule

bind casc_clkdiv casc_clkdiv_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state_q),
    .pcnt_i    (pcnt),
    .pre_i     (pre_q),
    .dcnt0_i   (dcnt_w[0]),
    .dcnt1_i   (dcnt_w[1]),
    .div0_i    (ocfg_q[0].div),
    .div1_i    (ocfg_q[1].div),
    .se0_i     (ocfg_q[0].se),
    .se1_i     (ocfg_q[1].se),
    .out1_p_i  (out1_p_o),
    .out1_n_i  (out1_n_o),
    .out2_p_i  (out2_p_o),
    .out2_n_i  (out2_n_o),
    .cfg_err_i (cfg_err_o)
);

// File: tb/casc_clkdiv_tb.sv
`timescale 1ns/1ps
module casc_clkdiv_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hold = 1'b0;
    logic [3:0] pre = 4'd5;
    logic [9:0] d1 = 10'd1;
    logic [9:0] d2 = 10'd1;
    logic [1:0] se = 2'b00;
    logic       o1p, o1n, o2p, o2n, err;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    casc_clkdiv u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .hold_i       (hold),
        .pre_ratio_i  (pre),
        .div1_ratio_i (d1),
        .div2_ratio_i (d2),
        .single_end_i (se),
        .out1_p_o     (o1p),
        .out1_n_o     (o1n),
        .out2_p_o     (o2p),
        .out2_n_o     (o2n),
        .cfg_err_o    (err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic pin(input int idx);
        return (idx == 1) ? o1p : o2p;
    endfunction

    task automatic apply(input int p, input int a, input int b, input logic [1:0] s, input logic h);
        rst_n = 1'b0;
        pre = 4'(p); d1 = 10'(a); d2 = 10'(b); se = s; hold = h;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic measure(input int idx, output int hi, output int lo);
        logic prev;
        logic cur;
        prev = pin(idx);
        forever begin
            @(negedge clk);
            cur = pin(idx);
            if (!prev && cur) break;
            prev = cur;
        end
        hi = 1;
        forever begin
            @(negedge clk);
            if (pin(idx)) hi++; else break;
        end
        lo = 1;
        forever begin
            @(negedge clk);
            if (!pin(idx)) lo++; else break;
        end
    endtask

    task automatic check_wave(input int idx, input int m, input string req);
        int hi;
        int lo;
        measure(idx, hi, lo);
        chk(hi + lo == m, req, hi + lo, m);
        chk(hi == (m + 1) / 2, req, hi, (m + 1) / 2);
        chk(lo == m / 2, req, lo, m / 2);
    endtask

    // R9: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({o1p, o1n, o2p, o2n, err} == 5'b0, "R9 reset pins", int'({o1p, o1n, o2p, o2n, err}), 0);
    endtask

    // R1 / R3: second-stage ratio 1 passes the prescaler wave through
    task automatic t_passthrough();
        apply(5, 1, 1, 2'b00, 1'b0);
        check_wave(1, 5, "R1 P=5 pass");
        apply(8, 1, 1, 2'b00, 1'b0);
        check_wave(2, 8, "R3 P=8 even");
        apply(11, 1, 1023, 2'b00, 1'b0);
        check_wave(1, 11, "R1 P=11 pass");
        check_wave(2, 11253, "R3 max ratio odd");
    endtask

    // R2: independent second stages
    task automatic t_independent();
        apply(6, 4, 25, 2'b00, 1'b0);
        check_wave(1, 24, "R2 out1");
        check_wave(2, 150, "R2 out2");
        apply(7, 3, 2, 2'b00, 1'b0);
        check_wave(1, 21, "R3 odd 21");
        check_wave(2, 14, "R2 out2 14");
    endtask

    // R4: settings captured once after reset
    task automatic t_latch();
        apply(6, 2, 3, 2'b00, 1'b0);
        pre = 4'd9; d1 = 10'd5; d2 = 10'd7; se = 2'b11;
        check_wave(1, 12, "R4 ignored change out1");
        check_wave(2, 18, "R4 ignored change out2");
        chk(o1n == ~o1p, "R4 mode ignored", int'(o1n), int'(~o1p));
        apply(9, 5, 7, 2'b00, 1'b0);
        check_wave(1, 45, "R4 new after reset");
        check_wave(2, 63, "R4 new after reset");
    endtask

    // R5 / R6: hold parks outputs, release realigns them
    task automatic t_hold();
        int bad;
        int mis;
        logic p1;
        logic p2;
        apply(5, 2, 6, 2'b10, 1'b0);
        repeat (17) @(negedge clk);
        hold = 1'b1;
        repeat (3) @(negedge clk);
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (o1p || o2p || !o1n || o2n) bad++;
        end
        chk(bad == 0, "R5 static during hold", bad, 0);
        hold = 1'b0;
        @(negedge clk);
        chk(!o1p && !o2p, "R6 low before restart", int'({o1p, o2p}), 0);
        @(negedge clk);
        chk(o1p && o2p, "R6 joint first rise", int'({o1p, o2p}), 3);
        mis = 0;
        p1 = o1p; p2 = o2p;
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            if (!p2 && o2p && !(!p1 && o1p)) mis++;
            p1 = o1p; p2 = o2p;
        end
        chk(mis == 0, "R6 aligned edges", mis, 0);
        check_wave(1, 10, "R6 out1 after release");
        check_wave(2, 30, "R6 out2 after release");
    endtask

    // R7: complementary pin mode
    task automatic t_mode();
        int b1;
        int b2;
        apply(5, 3, 2, 2'b10, 1'b0);
        b1 = 0; b2 = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (o1n != ~o1p) b1++;
            if (o2n != o2p) b2++;
        end
        chk(b1 == 0, "R7 differential out1", b1, 0);
        chk(b2 == 0, "R7 single-ended out2", b2, 0);
        apply(5, 3, 2, 2'b01, 1'b0);
        b1 = 0; b2 = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (o1n != o1p) b1++;
            if (o2n != ~o2p) b2++;
        end
        chk(b1 == 0, "R7 single-ended out1", b1, 0);
        chk(b2 == 0, "R7 differential out2", b2, 0);
    endtask

    task automatic bad_case(input int p, input int a, input int b, input string req);
        int bad;
        apply(p, a, b, 2'b00, 1'b0);
        bad = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!err || o1p || o1n || o2p || o2n) bad++;
        end
        chk(bad == 0, req, bad, 0);
    endtask

    // R8: illegal configurations
    task automatic t_invalid();
        bad_case(4, 3, 3, "R8 prescaler 4");
        bad_case(12, 3, 3, "R8 prescaler 12");
        bad_case(7, 0, 3, "R8 div1 zero");
        bad_case(7, 3, 0, "R8 div2 zero");
        apply(7, 3, 3, 2'b00, 1'b0);
        chk(err == 1'b0, "R8 legal clears", int'(err), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1..: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_passthrough();
        t_independent();
        t_latch();
        t_hold();
        t_mode();
        t_invalid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule